// File: doc/BRIEF.md
# Differential Biphase Line Codec

This block turns a stream of already scrambled NRZ bits into a two-level biphase line signal, and carries a matching receiver that turns such a line back into NRZ bits. On the transmit side, each bit is first XOR-ed with the previous precoded value. The precoded value is then sent as one bit cell of two equal halves. The direction of the level change at the middle of the cell carries the precoded symbol. A rising change means 1 and a falling change means 0.

Time on the line is measured in half-cells. A single clock enable, `half_tick`, marks every half-cell boundary. Every register in the block advances only on that enable. The encoder asks for the next data bit with `bit_req` in the same cycle in which it samples `tx_bit`. A transmit gate, `tx_on`, acts only at cell boundaries: when it is low there, the line parks at a fixed idle level and the precoder keeps its value.

The receiver samples the line once per half-cell. It takes the symbol from the second half, undoes the XOR precoding against the previous symbol, and flags a cell whose two halves are equal.

Encoder states: `ENC_IDLE` (line parked), `ENC_HEAD` (first half on the line), `ENC_TAIL` (second half on the line). Encoder transitions: idle to head and tail to head when a tick arrives with `tx_on` high (start cell); head to tail on every tick (mid-cell); tail to idle when a tick arrives with `tx_on` low (park).

Decoder states: `DEC_HEAD` (waiting for a first-half sample), `DEC_TAIL` (waiting for a second-half sample). Decoder transitions: head to tail when a tick arrives with `rx_on` high (capture first half); tail to head on every tick (capture second half and emit).

Top module: `dbp_codec`

## Requirements
- R1: After reset `line_out` equals the parameter `IDLE_LVL`, `bit_req`, `rx_valid` and `rx_viol` are 0, and both the precoder register and the receiver's previous-symbol register hold 0.
- R2: On each cell start the precoded symbol is d = `tx_bit` XOR (previous d), and d becomes the new previous value.
- R3: Each cell lasts exactly two `half_tick` periods. The second-half level is always the inverse of the first-half level, so every cell has a mid-cell change. `line_out` changes only in the cycle after a `half_tick`.
- R4: Polarity: a symbol d=0 is sent as high then low (falling mid-cell change). A symbol d=1 is sent as low then high (rising).
- R5: `bit_req` is high, combinationally, exactly in a cycle that has `half_tick` high, `tx_on` high, and the encoder not in its first half. `tx_bit` is sampled in that cycle.
- R6: A `half_tick` with `tx_on` low that falls on a cell boundary sets `line_out` to `IDLE_LVL`, and the line stays there while parked. A cell already started always completes. The precoder value is kept, so the next cell after a park continues the chain.
- R7: On the tick that captures a second half s, where the first half differed from s, `rx_valid` pulses for one cycle and `rx_bit` = s XOR (previous symbol). Symbol s becomes the previous symbol.
- R8: If the two captured halves are equal, `rx_viol` pulses for one cycle instead of `rx_valid`, and the previous-symbol register is left unchanged.
- R9: The receiver captures a first half only on a tick with `rx_on` high. The tick after that always captures the second half. While `rx_on` is low between cells, no output pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_tick | input | 1 | Half-cell clock enable (2x bit rate) |
| tx_on | input | 1 | Transmit gate, acts at cell boundaries |
| tx_bit | input | 1 | NRZ data bit, sampled when `bit_req` is high |
| bit_req | output | 1 | Data bit taken this cycle |
| line_out | output | 1 | Biphase line level |
| rx_on | input | 1 | Receiver gate for first-half capture |
| rx_line | input | 1 | Received line level |
| rx_valid | output | 1 | One-cycle pulse: `rx_bit` is valid |
| rx_bit | output | 1 | Recovered NRZ bit |
| rx_viol | output | 1 | One-cycle pulse: cell without mid-cell change |

## Verification
The bench builds the codec with `IDLE_LVL` set to 1. The parked level is therefore distinguishable from the reset values of the other outputs. A 0-symbol whose first half is high can also be told apart from the idle line only by its falling change. Varying gaps between `half_tick` pulses bring within reach the check that the line holds still between ticks. Random drops of `tx_on` exercise parks that occur mid-chain. A forced receive path reaches the violation cases, which a correct encoder never produces.

// File: rtl/dbp_pkg.sv
package dbp_pkg;

    typedef enum logic [1:0] {
        ENC_IDLE = 2'd0,
        ENC_HEAD = 2'd1,
        ENC_TAIL = 2'd2
    } enc_state_t;

    typedef enum logic {
        DEC_HEAD = 1'b0,
        DEC_TAIL = 1'b1
    } dec_state_t;

    typedef struct packed {
        logic valid;
        logic data;
        logic viol;
    } dec_out_t;

endpackage

// File: rtl/dbp_enc.sv
module dbp_enc
    import dbp_pkg::*;
#(
    parameter bit IDLE_LVL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic half_tick,
    input  logic tx_on,
    input  logic tx_bit,
    output logic bit_req,
    output logic line_out
);

    enc_state_t state_q, state_d;
    logic       diff_q;
    logic       diff_d;
    logic       line_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENC_IDLE: if (half_tick && tx_on) state_d = ENC_HEAD;
            ENC_HEAD: if (half_tick)          state_d = ENC_TAIL;
            ENC_TAIL: if (half_tick)          state_d = tx_on ? ENC_HEAD : ENC_IDLE;
            default:                          state_d = ENC_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ENC_IDLE;
        else        state_q <= state_d;
    end

    assign bit_req = half_tick && tx_on && (state_q != ENC_HEAD);
    assign diff_d  = tx_bit ^ diff_q;

    // output and precoder registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            diff_q <= 1'b0;
            line_q <= IDLE_LVL;
        end else if (bit_req) begin
            diff_q <= diff_d;
            line_q <= ~diff_d;
        end else if (half_tick) begin
            if (state_q == ENC_HEAD) line_q <= diff_q;
            else                     line_q <= IDLE_LVL;
        end
    end

    assign line_out = line_q;

    a_r3_mid_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (half_tick && state_q == ENC_HEAD) |=> (line_q != $past(line_q)));

    a_r3_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !half_tick |=> $stable(line_q));

    a_r2_head_level: assert property (@(posedge clk) disable iff (!rst_n)
        bit_req |=> (line_q == ~($past(tx_bit) ^ $past(diff_q))));

    a_r6_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ENC_IDLE) |-> (line_q == IDLE_LVL));

    a_r6_diff_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_req |=> $stable(diff_q));

endmodule

// File: rtl/dbp_dec.sv
module dbp_dec
    import dbp_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     half_tick,
    input  logic     rx_on,
    input  logic     rx_line,
    output dec_out_t dout
);

    dec_state_t state_q, state_d;
    logic       head_q;
    logic       prev_q;
    dec_out_t   out_q;
    logic       tail_tick;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DEC_HEAD: if (half_tick && rx_on) state_d = DEC_TAIL;
            DEC_TAIL: if (half_tick)          state_d = DEC_HEAD;
            default:                          state_d = DEC_HEAD;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DEC_HEAD;
        else        state_q <= state_d;
    end

    assign tail_tick = half_tick && (state_q == DEC_TAIL);

    // sample and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q <= 1'b0;
            prev_q <= 1'b0;
            out_q  <= '0;
        end else begin
            out_q.valid <= 1'b0;
            out_q.viol  <= 1'b0;
            if (half_tick && rx_on && state_q == DEC_HEAD) begin
                head_q <= rx_line;
            end
            if (tail_tick) begin
                if (head_q == rx_line) begin
                    out_q.viol <= 1'b1;
                end else begin
                    out_q.valid <= 1'b1;
                    out_q.data  <= rx_line ^ prev_q;
                    prev_q      <= rx_line;
                end
            end
        end
    end

    assign dout = out_q;

    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        out_q.valid |-> !out_q.viol);

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_q.valid |=> !out_q.valid);

    a_r8_prev_kept: assert property (@(posedge clk) disable iff (!rst_n)
        out_q.viol |-> $stable(prev_q));

    a_r9_tail_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (half_tick && rx_on && state_q == DEC_HEAD) |=> (state_q == DEC_TAIL));

endmodule

// File: rtl/dbp_codec.sv
module dbp_codec
    import dbp_pkg::*;
#(
    parameter bit IDLE_LVL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic half_tick,
    input  logic tx_on,
    input  logic tx_bit,
    output logic bit_req,
    output logic line_out,
    input  logic rx_on,
    input  logic rx_line,
    output logic rx_valid,
    output logic rx_bit,
    output logic rx_viol
);

    dec_out_t dec_o;

    dbp_enc #(.IDLE_LVL(IDLE_LVL)) u_enc (
        .clk       (clk),
        .rst_n     (rst_n),
        .half_tick (half_tick),
        .tx_on     (tx_on),
        .tx_bit    (tx_bit),
        .bit_req   (bit_req),
        .line_out  (line_out)
    );

    dbp_dec u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .half_tick (half_tick),
        .rx_on     (rx_on),
        .rx_line   (rx_line),
        .dout      (dec_o)
    );

    assign rx_valid = dec_o.valid;
    assign rx_bit   = dec_o.data;
    assign rx_viol  = dec_o.viol;

endmodule

// File: tb/sim_dbp_codec.sv
module sim_dbp_codec;

    localparam int CLK_PERIOD = 10;
    localparam bit IDLE = 1'b1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic half_tick = 1'b0;
    logic tx_on = 1'b0;
    logic tx_bit = 1'b0;
    logic rx_on = 1'b0;
    logic force_rx = 1'b0;
    logic rx_drive = 1'b0;
    logic bit_req, line_out, rx_line, rx_valid, rx_bit, rx_viol;

    int n_chk = 0;
    int n_bad = 0;

    // bench model state
    int   mst = 0;          // 0 parked, 1 first half, 2 second half
    logic mdiff = 1'b0;
    logic mprev = 1'b0;
    logic prev_on = 1'b0;
    logic sent [0:4095];
    int   widx = 0;
    int   ridx = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign rx_line = force_rx ? rx_drive : line_out;

    dbp_codec #(.IDLE_LVL(IDLE)) u0 (
        .clk(clk), .rst_n(rst_n), .half_tick(half_tick),
        .tx_on(tx_on), .tx_bit(tx_bit), .bit_req(bit_req), .line_out(line_out),
        .rx_on(rx_on), .rx_line(rx_line),
        .rx_valid(rx_valid), .rx_bit(rx_bit), .rx_viol(rx_viol)
    );

    function automatic logic first_half(input logic d);
        return ~d;
    endfunction

    function automatic logic nrz_back(input logic s, input logic p);
        return s ^ p;
    endfunction

    task automatic check(input logic ok, input string req, input logic act, input logic exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // one half-cell of loopback traffic
    task automatic enc_tick(input logic b, input logic on, input int gap);
        logic exp_line;
        tx_bit = b;
        tx_on = on;
        rx_on = prev_on;
        half_tick = 1'b1;
        #1;
        check(bit_req == (on && mst != 1), "R5 bit_req", bit_req, on && mst != 1);
        @(posedge clk);
        @(negedge clk);
        half_tick = 1'b0;
        if (mst == 1) begin
            mst = 2;
            exp_line = mdiff;
        end else if (on) begin
            mdiff = b ^ mdiff;
            sent[widx % 4096] = b;
            widx++;
            mst = 1;
            exp_line = first_half(mdiff);
        end else begin
            mst = 0;
            exp_line = IDLE;
        end
        if (mst == 0) check(line_out == exp_line, "R6 idle", line_out, exp_line);
        else          check(line_out == exp_line, "R2 R4 line", line_out, exp_line);
        check(!rx_viol, "R8 no viol on clean line", rx_viol, 1'b0);
        if (rx_valid) begin
            check(rx_bit == sent[ridx % 4096], "R7 decoded bit", rx_bit, sent[ridx % 4096]);
            ridx++;
        end
        prev_on = on;
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            check(line_out == exp_line, "R3 hold", line_out, exp_line);
            check(!rx_valid, "R7 pulse width", rx_valid, 1'b0);
        end
    endtask

    // one half-cell with the receive line driven by the bench
    task automatic dec_tick(input logic lvl, input logic on,
                            input logic exp_v, input logic exp_b, input logic exp_x);
        rx_drive = lvl;
        rx_on = on;
        half_tick = 1'b1;
        @(posedge clk);
        @(negedge clk);
        half_tick = 1'b0;
        check(rx_valid == exp_v, "R7 R9 valid", rx_valid, exp_v);
        check(rx_viol == exp_x, "R8 viol", rx_viol, exp_x);
        if (exp_v) check(rx_bit == exp_b, "R7 bit", rx_bit, exp_b);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(line_out == IDLE, "R1 line", line_out, IDLE);
        check(!rx_valid && !rx_viol, "R1 rx flags", rx_valid | rx_viol, 1'b0);
        check(!bit_req, "R1 bit_req", bit_req, 1'b0);

        // directed: first bit 1 from reset precoder 0 -> d=1, low then high (R2 R4)
        enc_tick(1'b1, 1'b1, 0);
        enc_tick(1'b0, 1'b1, 1);
        // next bit 1 -> d=0, high then low
        enc_tick(1'b1, 1'b1, 0);
        enc_tick(1'b0, 1'b1, 2);
        // drop tx_on mid-cell: cell completes (R6)
        enc_tick(1'b0, 1'b1, 0);
        enc_tick(1'b1, 1'b0, 0);
        // park at boundary, hold, precoder kept
        enc_tick(1'b1, 1'b0, 3);
        enc_tick(1'b0, 1'b0, 1);
        enc_tick(1'b1, 1'b1, 0);
        enc_tick(1'b0, 1'b1, 0);

        // random traffic
        for (int i = 0; i < 3000; i++) begin
            logic on;
            on = ($urandom % 8) != 0;
            enc_tick(1'($urandom), on, int'($urandom % 3));
        end
        // park both sides
        enc_tick(1'b0, 1'b0, 0);
        enc_tick(1'b0, 1'b0, 0);
        enc_tick(1'b0, 1'b0, 0);
        check(ridx == widx, "R7 all bits decoded", ridx == widx, 1'b1);
        // receiver's previous symbol equals the last precoded symbol
        mprev = mdiff;

        // forced receive line
        force_rx = 1'b1;
        tx_on = 1'b0;
        // R9: rx_on low, no capture, no pulses
        dec_tick(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        dec_tick(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        // R8: equal halves high/high
        dec_tick(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        dec_tick(1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        // rising cell -> symbol 1
        dec_tick(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        dec_tick(1'b1, 1'b1, 1'b1, nrz_back(1'b1, mprev), 1'b0);
        mprev = 1'b1;
        // falling cell -> symbol 0
        dec_tick(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        dec_tick(1'b0, 1'b1, 1'b1, nrz_back(1'b0, mprev), 1'b0);
        mprev = 1'b0;
        // R8: low/low, previous symbol kept
        dec_tick(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        dec_tick(1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
        // falling cell after violation: 0 xor kept 0 = 0
        dec_tick(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        dec_tick(1'b0, 1'b0, 1'b1, nrz_back(1'b0, mprev), 1'b0);
        // R9: tail captured even with rx_on low; then idle
        dec_tick(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        dec_tick(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule